// File: doc/BRIEF.md
# Serial Flash Read-Command Slave

This block is the slave side of a four-wire serial link for the read-type commands of a 256 KB serial flash. It runs entirely on the system clock. Chip-select, serial clock and serial data are brought in through synchronizers, and edges of the serial clock are detected from the synchronized level. Each frame opens when chip-select goes low. The block takes in an 8-bit opcode and, for the commands that need one, a 3-byte address and a dummy byte. It then streams bytes on the serial output until chip-select returns high.

Payload bytes come from one of three places: a synchronous memory read port with one cycle of latency, two status byte inputs, or fixed identification constants. Each byte is fetched before the serial clock edge that starts it. The serial output is registered and comes with a separate output-enable, which stands in for the high-impedance state. The serial clock may idle at either level. Each serial clock phase must last at least six system clocks.

Top module: `spi_rd_engine`

## Requirements
- R1: After reset, and during opcode, address and dummy bits, `spi_so_oe` is 0 and `mem_rd` is 0. `spi_so_oe` goes to 1 only at the first output falling edge.
- R2: When chip-select rises, `spi_so_oe` drops within a few system clocks. A chip-select rise before the last header bit cancels the command, so no memory read takes place. The next frame is decoded from scratch.
- R3: Opcode 0x03 takes 24 address bits, MSB first. Output starts at the first falling edge after the last address bit. It returns the memory byte at that address, MSB first, and then the bytes at each following address.
- R4: Opcode 0x0B takes the 24 address bits and then 8 ignored dummy bits, with output held off during the dummy bits. After that it returns the same data as R3.
- R5: The read address wraps from 0x3FFFF to 0x00000.
- R6: Address bits 23..18 have no effect on which memory location is read.
- R7: Opcode 0x05 returns `stat_a` and opcode 0x35 returns `stat_b`, repeated on every byte until chip-select rises. The value sent in each byte is the one the input holds at that byte's first falling edge.
- R8: Opcode 0x9F returns 0xBF, 0x25, 0x8C and then starts the sequence again.
- R9: Opcodes 0x90 and 0xAB take a 3-byte address and alternate between 0xBF and 0x8C. The output starts with 0xBF when address bit 0 is 0 and with 0x8C when it is 1.
- R10: Any other opcode keeps `spi_so_oe` at 0 and issues no memory read for the rest of the frame.
- R11: The behaviour is the same whether the serial clock idles low or idles high.
- R12: While chip-select is low, `spi_so` changes only after a falling serial clock edge.
- R13: `mem_rd` is a one-cycle pulse. `mem_addr` changes only together with it. Exactly one read is issued for the first byte, and one more each time an output byte starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_si | input | 1 | Serial data from the master |
| spi_so | output | 1 | Serial data to the master |
| spi_so_oe | output | 1 | Output enable for `spi_so`; 0 means high impedance |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 18 | Memory byte address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd` |
| stat_a | input | 8 | First status byte |
| stat_b | input | 8 | Second status byte |

## Verification
The bench reads across the 0x3FFFF boundary. A design that missed the wrap would return 0x40000-derived data or stall. Addresses are sent with the top six bits set: an engine that kept those bits would read the wrong location. Fast read is checked for output during the dummy byte and for a one-byte shift in the data. The legacy ID is started from both parities of address bit 0, and the JEDEC-style ID is read past its third byte. The status input is changed between bytes, which exposes a design that latches it once per frame. Two more cases close the run: a frame cut off inside the address, and an unknown opcode. A design that did not cancel or ignore these would drive the line or touch memory.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_FAST    = 8'h0B;
  localparam logic [7:0] OP_STAT_A  = 8'h05;
  localparam logic [7:0] OP_STAT_B  = 8'h35;
  localparam logic [7:0] OP_JID     = 8'h9F;
  localparam logic [7:0] OP_LID_A   = 8'h90;
  localparam logic [7:0] OP_LID_B   = 8'hAB;

  typedef enum logic [2:0] {SRC_MEM, SRC_ST_A, SRC_ST_B, SRC_JID, SRC_LID} src_e;
  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_SKIP} phase_e;

  typedef struct packed {
    logic valid;
    logic has_addr;
    logic fast;
    src_e src;
  } op_info_t;

  function automatic op_info_t op_decode(input logic [7:0] op);
    op_info_t r;
    r.valid = 1'b1;
    r.has_addr = 1'b0;
    r.fast = 1'b0;
    r.src = SRC_MEM;
    case (op)
      OP_READ:            r.has_addr = 1'b1;
      OP_FAST:            begin r.has_addr = 1'b1; r.fast = 1'b1; end
      OP_STAT_A:          r.src = SRC_ST_A;
      OP_STAT_B:          r.src = SRC_ST_B;
      OP_JID:             r.src = SRC_JID;
      OP_LID_A, OP_LID_B: begin r.has_addr = 1'b1; r.src = SRC_LID; end
      default:            r.valid = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_rd_edge.sv
module spi_rd_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              data_en,
  input  logic              sck_fall,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              so,
  output logic              so_oe,
  output logic              take
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bitc;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      bitc  <= '0;
      sh    <= '0;
      so    <= 1'b0;
      so_oe <= 1'b0;
      take  <= 1'b0;
    end else begin
      take <= 1'b0;
      if (data_en && sck_fall) begin
        so_oe <= 1'b1;
        bitc  <= bitc + 1'b1;
        if (bitc == '0) begin
          so   <= load_byte[BYTE_W-1];
          sh   <= {load_byte[BYTE_W-2:0], 1'b0};
          take <= 1'b1;
        end else begin
          so <= sh[BYTE_W-1];
          sh <= {sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int         ADDR_W = 18,
  parameter logic [7:0] ID0    = 8'hBF,
  parameter logic [7:0] ID1    = 8'h25,
  parameter logic [7:0] ID2    = 8'h8C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              si_bit,
  input  logic              take,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        stat_a,
  input  logic [7:0]        stat_b,
  output logic              data_en,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        nxt_byte
);
  localparam int               HDR_ADDR_BITS = 24;
  localparam logic [4:0]       LAST_BYTE_BIT = 5'd7;
  localparam logic [4:0]       LAST_ADDR_BIT = 5'(HDR_ADDR_BITS - 1);
  localparam logic [ADDR_W-1:0] ADDR_ONE     = ADDR_W'(1);

  phase_e            ph;
  src_e              src;
  logic              fast;
  logic [4:0]        cnt;
  logic [6:0]        op_sh;
  logic [ADDR_W-1:0] ptr;
  logic [1:0]        idx;
  logic              kick;
  logic              rd_q;
  op_info_t          dec;
  logic [7:0]        id_sel;

  always_comb dec = op_decode({op_sh, si_bit});

  always_comb begin
    if (src == SRC_LID) id_sel = idx[0] ? ID2 : ID0;
    else begin
      case (idx)
        2'd0:    id_sel = ID0;
        2'd1:    id_sel = ID1;
        default: id_sel = ID2;
      endcase
    end
  end

  assign data_en = (ph == PH_DATA);

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      ph     <= PH_CMD;
      src    <= SRC_MEM;
      fast   <= 1'b0;
      cnt    <= '0;
      op_sh  <= '0;
      ptr    <= '0;
      idx    <= '0;
      kick   <= 1'b0;
      rd_q   <= 1'b0;
      mem_rd <= 1'b0;
    end else begin
      kick   <= 1'b0;
      mem_rd <= 1'b0;
      rd_q   <= mem_rd;
      if (sck_rise) begin
        case (ph)
          PH_CMD: begin
            op_sh <= {op_sh[5:0], si_bit};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BYTE_BIT) begin
              cnt  <= '0;
              src  <= dec.src;
              fast <= dec.fast;
              idx  <= '0;
              if (!dec.valid)       ph <= PH_SKIP;
              else if (dec.has_addr) ph <= PH_ADDR;
              else begin
                ph   <= PH_DATA;
                kick <= 1'b1;
              end
            end
          end
          PH_ADDR: begin
            ptr <= {ptr[ADDR_W-2:0], si_bit};
            cnt <= cnt + 1'b1;
            if (cnt == LAST_ADDR_BIT) begin
              cnt <= '0;
              idx <= {1'b0, si_bit};
              if (fast) ph <= PH_DUMMY;
              else begin
                ph   <= PH_DATA;
                kick <= 1'b1;
              end
            end
          end
          PH_DUMMY: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BYTE_BIT) begin
              cnt  <= '0;
              ph   <= PH_DATA;
              kick <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (take) begin
        kick <= 1'b1;
        ptr  <= ptr + ADDR_ONE;
        if (src == SRC_LID) idx <= {1'b0, ~idx[0]};
        else                idx <= (idx == 2'd2) ? 2'd0 : idx + 2'd1;
      end
      if (kick && src == SRC_MEM) mem_rd <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      nxt_byte <= '0;
    end else begin
      if (cs_act && kick && src == SRC_MEM) mem_addr <= ptr;
      case (src)
        SRC_ST_A: nxt_byte <= stat_a;
        SRC_ST_B: nxt_byte <= stat_b;
        SRC_JID, SRC_LID: if (kick) nxt_byte <= id_sel;
        default:  if (rd_q) nxt_byte <= mem_rdata;
      endcase
    end
  end
endmodule

// File: rtl/spi_rd_engine.sv
module spi_rd_engine #(
  parameter int ADDR_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        stat_a,
  input  logic [7:0]        stat_b
);
  logic sck_lvl, cs_lvl, si_lvl;
  logic sck_rise, sck_fall;
  logic cs_act, data_en, take;
  logic [7:0] nxt_byte;

  spi_rd_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sck_sync (
    .clk(clk), .rst(rst), .din(spi_sck), .dout(sck_lvl));
  spi_rd_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .din(spi_cs_n), .dout(cs_lvl));
  spi_rd_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_si_sync (
    .clk(clk), .rst(rst), .din(spi_si), .dout(si_lvl));

  spi_rd_edge u_sck_edge (
    .clk(clk), .rst(rst), .lvl(sck_lvl), .rise(sck_rise), .fall(sck_fall));

  assign cs_act = ~cs_lvl;

  spi_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise),
    .si_bit(si_lvl), .take(take), .mem_rdata(mem_rdata),
    .stat_a(stat_a), .stat_b(stat_b), .data_en(data_en),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .nxt_byte(nxt_byte));

  spi_rd_tx #(.BYTE_W(8)) u_tx (
    .clk(clk), .rst(rst), .cs_act(cs_act), .data_en(data_en),
    .sck_fall(sck_fall), .load_byte(nxt_byte), .so(spi_so),
    .so_oe(spi_so_oe), .take(take));
endmodule

// File: rtl/spi_rd_engine_chk.sv
module spi_rd_engine_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              sck_fall,
  input logic              data_en,
  input logic              spi_so,
  input logic              spi_so_oe,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr
);
  // R1
  oe_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    spi_so_oe |-> data_en);

  // R2
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_so_oe);

  // R12
  so_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !sck_fall) |=> $stable(spi_so));

  // R12
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_so_oe) |-> $past(sck_fall));

  // R13
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R13
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr) |-> mem_rd);
endmodule

bind spi_rd_engine spi_rd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .sck_fall(sck_fall),
  .data_en(data_en), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
  .mem_rd(mem_rd), .mem_addr(mem_addr));

// File: tb/tb_spi_rd_engine.sv
`timescale 1ns/1ps
module tb_spi_rd_engine;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, mem_rd;
  logic [17:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] stat_a = 8'h5A, stat_b = 8'hC3;
  logic cpol = 1'b0;
  int checks = 0, fails = 0, rd_count = 0;
  logic [7:0] got [8];

  always #2.5 clk = ~clk;

  spi_rd_engine dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_so(so), .spi_so_oe(so_oe), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .stat_a(stat_a), .stat_b(stat_b));

  function automatic logic [7:0] pat(input logic [17:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ {a[17:16], 6'h15};
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= pat(mem_addr);
      rd_count  <= rd_count + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic frame_start();
    sck = cpol;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic frame_end();
    if (!cpol) begin sck = 1'b0; wait_clk(H); end
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic bit_x(input logic b, output logic sob, output logic oeb);
    sck = 1'b0;
    si = b;
    wait_clk(H);
    sob = so;
    oeb = so_oe;
    sck = 1'b1;
    wait_clk(H);
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx,
                        output logic oe_any, output logic oe_all);
    logic sb, ob;
    oe_any = 1'b0;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], sb, ob);
      rx[i] = sb;
      oe_any |= ob;
      oe_all &= ob;
    end
  endtask

  // header + n data bytes into got[]; returns whether oe was seen in header
  task automatic frame(input logic [7:0] op, input bit has_addr, input bit fast,
                       input logic [23:0] addr, input int n, output logic hdr_oe,
                       output logic data_oe);
    logic [7:0] rx;
    logic oa, ol;
    hdr_oe = 1'b0;
    data_oe = 1'b1;
    frame_start();
    byte_x(op, rx, oa, ol); hdr_oe |= oa;
    if (has_addr) begin
      byte_x(addr[23:16], rx, oa, ol); hdr_oe |= oa;
      byte_x(addr[15:8],  rx, oa, ol); hdr_oe |= oa;
      byte_x(addr[7:0],   rx, oa, ol); hdr_oe |= oa;
    end
    if (fast) begin byte_x(8'hA5, rx, oa, ol); hdr_oe |= oa; end
    for (int k = 0; k < n; k++) begin
      byte_x(8'h00, rx, oa, ol);
      got[k] = rx;
      data_oe &= ol;
    end
    frame_end();
  endtask

  task automatic t_reset();
    chk("R1 reset oe", so_oe, 0);
    chk("R1 reset mem_rd", mem_rd, 0);
  endtask

  task automatic t_read(input string req, input logic [7:0] op, input bit fast,
                        input logic [23:0] addr, input int n);
    logic h, d;
    rd_count = 0;
    frame(op, 1'b1, fast, addr, n, h, d);
    chk({req, " R1 header oe"}, h, 0);
    chk({req, " data oe"}, d, 1);
    for (int k = 0; k < n; k++)
      chk({req, " data byte"}, got[k], pat(18'(addr[17:0] + 18'(k))));
    chk({req, " R2 oe after cs"}, so_oe, 0);
    chk({req, " R13 read count"}, rd_count, n + 1 + (cpol ? 0 : 1));
  endtask

  task automatic t_status();
    logic [7:0] rx;
    logic oa, ol;
    stat_a = 8'h5A;
    frame_start();
    byte_x(8'h05, rx, oa, ol);
    chk("R1 status header oe", oa, 0);
    byte_x(8'h00, rx, oa, ol); chk("R7 status a byte0", rx, 8'h5A);
    byte_x(8'h00, rx, oa, ol); chk("R7 status a byte1", rx, 8'h5A);
    stat_a = 8'h81;
    byte_x(8'h00, rx, oa, ol); chk("R7 status a updated", rx, 8'h81);
    frame_end();
    frame_start();
    byte_x(8'h35, rx, oa, ol);
    byte_x(8'h00, rx, oa, ol); chk("R7 status b byte0", rx, 8'hC3);
    byte_x(8'h00, rx, oa, ol); chk("R7 status b byte1", rx, 8'hC3);
    frame_end();
  endtask

  task automatic t_jid();
    logic h, d;
    frame(8'h9F, 1'b0, 1'b0, 24'h0, 4, h, d);
    chk("R8 jid b0", got[0], 8'hBF);
    chk("R8 jid b1", got[1], 8'h25);
    chk("R8 jid b2", got[2], 8'h8C);
    chk("R8 jid repeat", got[3], 8'hBF);
  endtask

  task automatic t_lid();
    logic h, d;
    frame(8'h90, 1'b1, 1'b0, 24'h000000, 3, h, d);
    chk("R9 lid even b0", got[0], 8'hBF);
    chk("R9 lid even b1", got[1], 8'h8C);
    chk("R9 lid even b2", got[2], 8'hBF);
    frame(8'hAB, 1'b1, 1'b0, 24'h000001, 3, h, d);
    chk("R9 lid odd b0", got[0], 8'h8C);
    chk("R9 lid odd b1", got[1], 8'hBF);
    chk("R9 lid odd b2", got[2], 8'h8C);
  endtask

  task automatic t_unknown();
    logic h, d;
    logic [7:0] rx;
    logic oa, ol, any;
    rd_count = 0;
    any = 1'b0;
    frame_start();
    byte_x(8'h42, rx, oa, ol); any |= oa;
    for (int k = 0; k < 4; k++) begin byte_x(8'h03, rx, oa, ol); any |= oa; end
    frame_end();
    chk("R10 unknown op oe", any, 0);
    chk("R10 unknown op reads", rd_count, 0);
  endtask

  task automatic t_cancel();
    logic [7:0] rx;
    logic oa, ol, any, sb, ob;
    rd_count = 0;
    any = 1'b0;
    frame_start();
    byte_x(8'h03, rx, oa, ol); any |= oa;
    byte_x(8'h00, rx, oa, ol); any |= oa;
    byte_x(8'h00, rx, oa, ol); any |= oa;
    for (int k = 0; k < 4; k++) begin bit_x(1'b1, sb, ob); any |= ob; end
    frame_end();
    chk("R2 cancel oe", any, 0);
    chk("R2 cancel reads", rd_count, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_clk(6);
    rst = 1'b0;
    wait_clk(4);
    t_reset();
    cpol = 1'b0;
    t_read("R3 R11 idle-low", 8'h03, 1'b0, 24'h012345, 4);
    cpol = 1'b1;
    t_read("R3 R11 idle-high", 8'h03, 1'b0, 24'h012345, 4);
    t_read("R4 fast read", 8'h0B, 1'b1, 24'h000100, 3);
    cpol = 1'b0;
    t_read("R5 wrap", 8'h03, 1'b0, 24'h03FFFE, 4);
    t_read("R6 upper bits", 8'h03, 1'b0, 24'hFC0010, 2);
    t_status();
    t_jid();
    cpol = 1'b1;
    t_lid();
    t_unknown();
    t_cancel();
    cpol = 1'b0;
    t_cancel();
    t_read("R2 after cancel", 8'h0B, 1'b1, 24'h020000, 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule